// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block builds one deep FIFO out of `STAGES` identical first-word-fall-through stages placed in series on a single clock. Each stage presents the word at its head without being asked. It signals "data present" and "space present" with active-low flags. The data flag of one stage is the write strobe of the stage after it. The space flag of a stage is the read strobe of the stage before it. No glue logic sits between the stages. A word written into an empty chain moves down to the last stage by itself. A slot freed at the end of a full chain moves back up to the first stage by itself.

Producers see only the write side of the first stage. Consumers see only the read side of the last stage. All control signals are active low. A data flag at 0 means a word is on the output. A space flag at 0 means a write will be taken. A strobe at 0 means "write now" or "read now".

Inside a stage, one tally register set holds the state. On each clock it takes one of four named events: HOLD (no change), UP (an arrival only), DOWN (a departure only) and BOTH (one of each, no net change). Three such tallies run in each stage:
- the count of words visible to the reader;
- the count of slots visible to the writer;
- the true occupancy.

A write becomes visible to the reader three clocks after it is taken. A read becomes visible to the writer two clocks after it is taken.

Top module: `fifo_chain`

## Requirements
- R1: On the first clock after a synchronous active-high `rst`, every stage is empty, `pop_ready_n` is 1 (no data) and `push_ready_n` is 0 (space).
- R2: Words leave `pop_data` in the order they were pushed, with none lost or repeated. While `pop_ready_n` is 0 and `pop_n` is 1, the head word and the flag hold steady.
- R3: The chain accepts exactly `STAGES*DEPTH` words before `push_ready_n` settles at 1.
- R4: Take a word pushed into an empty chain at clock edge E. `pop_ready_n` falls right after edge E+(STAGES-1)*4+3, with no pop needed.
- R5: Take a word written into an empty stage at edge E. That stage's data flag falls right after edge E+3, and the next stage takes the word at edge E+4.
- R6: In a settled full chain, a pop at edge E makes `push_ready_n` fall right after edge E+(STAGES-1)*3+2.
- R7: Push a burst of up to `DEPTH` words on consecutive clocks into an empty chain while `pop_n` is held at 0. The words leave on consecutive clocks, with the first one present after the R4 delay.
- R8: A push with `push_n`=0 while `push_ready_n` is 1 is dropped. It adds no word to the chain.
- R9: A pop with `pop_n`=0 while `pop_ready_n` is 1 has no effect. `pop_ready_n` stays 1 and later words are unaffected.
- R10: No stage takes a write while it holds `DEPTH` words, and no stage takes a read while it holds none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, shared by all stages and transfers |
| rst | input | 1 | Synchronous reset, active high |
| push_n | input | 1 | Write strobe into the first stage, active low |
| push_data | input | WIDTH | Word to write |
| push_ready_n | output | 1 | 0 when the first stage will take a write |
| pop_n | input | 1 | Read strobe from the last stage, active low |
| pop_data | output | WIDTH | Head word of the last stage |
| pop_ready_n | output | 1 | 0 when `pop_data` holds a valid word |

## Verification
The bench builds three copies side by side with `STAGES` set to 1, 2 and 3, using `DEPTH`=4 and `WIDTH`=8. This lets it confirm that both the fill delay and the drain delay grow by exactly four and three clocks per added stage. The single-stage copy isolates the three-clock arrival step of one stage. The small depth keeps the chains short enough to fill completely, which makes the total capacity and the dropped pushes at full observable. A 4-word burst fits in one stage, so it shows gap-free streaming without hitting the backpressure that a deeper stage would need for sustained full rate.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

    // Clocks from a taken write to the reader seeing it, and from a taken
    // read to the writer seeing the freed slot.
    localparam int ARRIVE_LAT  = 3;
    localparam int RELEASE_LAT = 2;

    // Per-clock event seen by a tally: {increment, decrement}
    typedef enum logic [1:0] {
        FLOW_HOLD = 2'b00,
        FLOW_DOWN = 2'b01,
        FLOW_UP   = 2'b10,
        FLOW_BOTH = 2'b11
    } flow_e;

endpackage

// File: rtl/fifo_chain_pulse_dly.sv
module fifo_chain_pulse_dly #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic pulse_out
);

    logic [LAT-1:0] shift_q;

    generate
        if (LAT == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) shift_q <= '0;
                else     shift_q <= pulse_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) shift_q <= '0;
                else     shift_q <= {shift_q[LAT-2:0], pulse_in};
            end
        end
    endgenerate

    assign pulse_out = shift_q[LAT-1];

endmodule

// File: rtl/fifo_chain_tally.sv
module fifo_chain_tally
    import fifo_chain_pkg::*;
#(
    parameter int CW   = 3,
    parameter int INIT = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] value
);

    flow_e flow;

    always_comb flow = flow_e'({inc, dec});

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= CW'(INIT);
        end else begin
            unique case (flow)
                FLOW_HOLD, FLOW_BOTH: value <= value;
                FLOW_UP:              value <= value + 1'b1;
                FLOW_DOWN:            value <= value - 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/fifo_chain_stage.sv
module fifo_chain_stage
    import fifo_chain_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] din,
    output logic             ir_n,
    input  logic             rd_n,
    output logic [WIDTH-1:0] dout,
    output logic             or_n
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    vis_q, room_q, occ_q;
    logic             wr_acc, rd_acc, wr_land, rd_land;

    assign wr_acc = !wr_n && (room_q != '0);
    assign rd_acc = !rd_n && (vis_q != '0);

    fifo_chain_pulse_dly #(.LAT(ARRIVE_LAT)) u_arrive (
        .clk(clk), .rst(rst), .pulse_in(wr_acc), .pulse_out(wr_land));

    fifo_chain_pulse_dly #(.LAT(RELEASE_LAT)) u_release (
        .clk(clk), .rst(rst), .pulse_in(rd_acc), .pulse_out(rd_land));

    fifo_chain_tally #(.CW(CW), .INIT(0)) u_vis (
        .clk(clk), .rst(rst), .inc(wr_land), .dec(rd_acc), .value(vis_q));

    fifo_chain_tally #(.CW(CW), .INIT(DEPTH)) u_room (
        .clk(clk), .rst(rst), .inc(rd_land), .dec(wr_acc), .value(room_q));

    fifo_chain_tally #(.CW(CW), .INIT(0)) u_occ (
        .clk(clk), .rst(rst), .inc(wr_acc), .dec(rd_acc), .value(occ_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_acc) wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
            if (rd_acc) rptr_q <= (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wptr_q] <= din;
    end

    always_comb begin
        or_n = (vis_q == '0);
        ir_n = (room_q == '0);
        dout = mem[rptr_q];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_acc |-> (occ_q < FULL_CNT));                                   // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        rd_acc |-> (occ_q != '0));                                        // R10
    AST_ARRIVE_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && occ_q == '0) |-> ##4 $fell(or_n));                     // R5
    AST_RELEASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && occ_q == FULL_CNT) |-> ##3 $fell(ir_n));               // R6

endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
    import fifo_chain_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int DEPTH  = 4,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_n,
    input  logic [WIDTH-1:0] push_data,
    output logic             push_ready_n,
    input  logic             pop_n,
    output logic [WIDTH-1:0] pop_data,
    output logic             pop_ready_n
);

    // fwd_n[k]: write strobe into stage k; fwd_n[STAGES]: data flag of the tail
    // bwd_n[k]: space flag of stage k;     bwd_n[STAGES]: external pop strobe
    logic             fwd_n [STAGES+1];
    logic             bwd_n [STAGES+1];
    logic [WIDTH-1:0] link  [STAGES+1];

    assign fwd_n[0]      = push_n;
    assign link[0]       = push_data;
    assign bwd_n[STAGES] = pop_n;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            fifo_chain_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stage (
                .clk  (clk),
                .rst  (rst),
                .wr_n (fwd_n[k]),
                .din  (link[k]),
                .ir_n (bwd_n[k]),
                .rd_n (bwd_n[k+1]),
                .dout (link[k+1]),
                .or_n (fwd_n[k+1])
            );
        end
    endgenerate

    assign push_ready_n = bwd_n[0];
    assign pop_ready_n  = fwd_n[STAGES];
    assign pop_data     = link[STAGES];

    AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pop_ready_n && !push_ready_n));                   // R1
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pop_ready_n && pop_n) |=> (!pop_ready_n && $stable(pop_data))); // R2

endmodule

// File: tb/test_fifo_chain.sv
module test_fifo_chain;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int WIDTH      = 8;
    localparam int NDUT       = 3;

    typedef struct packed {
        logic [7:0] cnt;    // words to move; also the expected count out
        logic [7:0] wmask;  // push pattern, one bit per cycle
        logic [7:0] rmask;  // pop pattern, one bit per cycle
        logic [7:0] base;   // first data value
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'd10, 8'hFF, 8'hFF, 8'h10},
        '{8'd16, 8'hFF, 8'h55, 8'h40},
        '{8'd12, 8'h33, 8'hFF, 8'h80},
        '{8'd20, 8'hA5, 8'h0F, 8'hC0},
        '{8'd9,  8'h01, 8'hFF, 8'h20},
        '{8'd14, 8'hFF, 8'h81, 8'h60}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_n       [NDUT];
    logic [WIDTH-1:0] push_data    [NDUT];
    logic             push_ready_n [NDUT];
    logic             pop_n        [NDUT];
    logic [WIDTH-1:0] pop_data     [NDUT];
    logic             pop_ready_n  [NDUT];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    generate
        for (genvar g = 0; g < NDUT; g++) begin : g_n
            fifo_chain #(.STAGES(g+1), .DEPTH(DEPTH), .WIDTH(WIDTH)) i_fifo_chain (
                .clk          (clk),
                .rst          (rst),
                .push_n       (push_n[g]),
                .push_data    (push_data[g]),
                .push_ready_n (push_ready_n[g]),
                .pop_n        (pop_n[g]),
                .pop_data     (pop_data[g]),
                .pop_ready_n  (pop_ready_n[g])
            );
        end
    endgenerate

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < NDUT; i++) begin
            push_n[i] = 1'b1; pop_n[i] = 1'b1; push_data[i] = '0;
        end
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(input int d, input vec_t v);
        logic [7:0] q[$];
        int sent, got, cyc;
        logic wr, rd;
        logic [7:0] val;
        sent = 0; got = 0; cyc = 0;
        while (got < int'(v.cnt) && cyc < 3000) begin
            @(negedge clk);
            wr  = (sent < int'(v.cnt)) && v.wmask[cyc % 8];
            rd  = v.rmask[cyc % 8];
            val = v.base + 8'(sent);
            push_n[d] = !wr; push_data[d] = val; pop_n[d] = !rd;
            if (wr && !push_ready_n[d]) begin q.push_back(val); sent++; end
            if (rd && !pop_ready_n[d]) begin
                if (q.size() == 0) check_eq("R2 extra word", 1, 0);
                else begin
                    check_eq("R2 order", int'(pop_data[d]), int'(q[0]));
                    void'(q.pop_front());
                end
                got++;
            end
            cyc++;
        end
        @(negedge clk);
        push_n[d] = 1'b1; pop_n[d] = 1'b1;
        check_eq("R2 words out", got, int'(v.cnt));
        check_eq("R2 chain empty", int'(pop_ready_n[d]), 1);
    endtask

    initial begin
        for (int i = 0; i < NDUT; i++) begin
            push_n[i] = 1'b1; pop_n[i] = 1'b1; push_data[i] = '0;
        end

        // Table-driven traffic on every chain length
        for (int d = 0; d < NDUT; d++) begin
            for (int e = 0; e < 6; e++) begin
                do_reset();
                run_vec(d, VECS[e]);
            end
        end

        for (int d = 0; d < NDUT; d++) begin
            int n, lat, cnt, acc, hi;
            logic [7:0] q[$];
            n = d + 1;

            // R1 reset flags; R9 pops on an empty chain
            do_reset();
            check_eq("R1 pop_ready_n", int'(pop_ready_n[d]), 1);
            check_eq("R1 push_ready_n", int'(push_ready_n[d]), 0);
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                pop_n[d] = 1'b0;
                if (k > 0) check_eq("R9 empty pop", int'(pop_ready_n[d]), 1);
            end
            @(negedge clk);
            pop_n[d] = 1'b1;
            check_eq("R9 empty pop", int'(pop_ready_n[d]), 1);

            // R4 R5 fill latency
            @(negedge clk);
            push_n[d] = 1'b0; push_data[d] = 8'h5A;
            @(negedge clk);
            push_n[d] = 1'b1;
            cnt = 0;
            while (pop_ready_n[d] && cnt < 60) begin @(negedge clk); cnt++; end
            lat = (n - 1) * 4 + 3;
            check_eq((n == 1) ? "R5 stage fill" : "R4 chain fill", cnt, lat);
            check_eq("R2 R9 first word", int'(pop_data[d]), 8'h5A);
            pop_n[d] = 1'b0;
            @(negedge clk);
            pop_n[d] = 1'b1;
            check_eq("R9 drained", int'(pop_ready_n[d]), 1);

            // R7 burst of DEPTH words with pop held
            do_reset();
            pop_n[d] = 1'b0;
            acc = 0;
            for (int t = 0; t < lat + 12; t++) begin
                @(negedge clk);
                if (t > 0 && !pop_ready_n[d]) begin
                    check_eq("R7 slot", t, lat + 1 + acc);
                    check_eq("R7 data", int'(pop_data[d]), 8'hA0 + acc);
                    acc++;
                end
                push_n[d] = (t >= DEPTH);
                push_data[d] = 8'(8'hA0 + t);
            end
            pop_n[d] = 1'b1; push_n[d] = 1'b1;
            check_eq("R7 count", acc, DEPTH);

            // R3 R10 capacity
            do_reset();
            acc = 0; hi = 0;
            for (int t = 0; t < 400 && hi < 20; t++) begin
                @(negedge clk);
                push_n[d] = 1'b0; push_data[d] = 8'(t + 1);
                if (!push_ready_n[d]) begin q.push_back(8'(t + 1)); acc++; hi = 0; end
                else hi++;
            end
            @(negedge clk);
            push_n[d] = 1'b1;
            check_eq("R3 R10 capacity", acc, n * DEPTH);

            // R8 pushes into a full chain
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check_eq("R8 full flag", int'(push_ready_n[d]), 1);
                push_n[d] = 1'b0; push_data[d] = 8'hEE;
            end
            @(negedge clk);
            push_n[d] = 1'b1;

            // R6 drain latency
            @(negedge clk);
            check_eq("R2 full head", int'(pop_data[d]), int'(q[0]));
            void'(q.pop_front());
            pop_n[d] = 1'b0;
            @(negedge clk);
            pop_n[d] = 1'b1;
            cnt = 0;
            while (push_ready_n[d] && cnt < 60) begin @(negedge clk); cnt++; end
            check_eq("R6 drain", cnt, (n - 1) * 3 + 2);

            // Drain the rest; dropped pushes must not appear (R8)
            pop_n[d] = 1'b0;
            for (int t = 0; t < 200; t++) begin
                if (!pop_ready_n[d]) begin
                    if (q.size() == 0) check_eq("R8 dropped word seen", int'(pop_data[d]), -1);
                    else begin
                        check_eq("R2 drain order", int'(pop_data[d]), int'(q[0]));
                        void'(q.pop_front());
                    end
                end
                @(negedge clk);
            end
            pop_n[d] = 1'b1;
            check_eq("R8 R2 leftover", q.size(), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule